// File: doc/BRIEF.md
# Subtract Unit with x86-Style Status Flags

This block subtracts a source operand from a destination operand at one of four widths (8, 16, 32 or 64 bits). It returns the truncated difference and a 32-bit status word in which the six arithmetic flags are rebuilt from the operation. Every other bit of that word is copied from the incoming status word. An execution pipeline uses it for subtract and compare operations. In compare mode only the status word is updated. The result register keeps its earlier value and the operation is reported as not written.

Operands enter on a valid strobe together with a width code, a compare bit and the current status word. One clock later the outputs are registered and the output valid strobe is raised. Borrow is produced as the inverse of the carry out of an add-with-inverted-source. Overflow, sign and the carry position follow the active width. Parity and auxiliary carry always use the low byte and bit 4.

Top module: `sub_flag_unit`

## Requirements
- R1: The width code `width_sel` selects 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Operand bits above the active width are ignored. `result_o` carries the difference modulo 2^width, and its bits above the active width are zero.
- R2: Status bit 0 (borrow) is 1 exactly when the destination, truncated to the active width, is below the truncated source as unsigned numbers.
- R3: Status bit 2 (parity) is 1 when bits 7..0 of the result hold an even number of ones, whatever the active width.
- R4: Status bit 4 (half borrow) equals bit 4 of (destination XOR source XOR result). This is 1 when the low nibble of the destination is below the low nibble of the source.
- R5: Status bit 11 (overflow) is 1 when the truncated operands have different sign bits and the sign of the result differs from the sign of the destination.
- R6: Status bit 6 (zero) is 1 when the truncated result is zero. Status bit 7 (sign) equals the top bit of the truncated result.
- R7: Status-word bits other than 0, 2, 4, 6, 7 and 11 are copied unchanged from `flags_i` to `flags_o`.
- R8: When `cmp_mode` is 1 with `in_valid`, the flags are updated, `result_o` keeps its previous value and `result_written` is 0. Otherwise an accepted operation sets `result_written` to 1.
- R9: Outputs appear one clock after `in_valid`. `out_valid` is high for exactly the cycles following accepted inputs. Reset clears `out_valid`, `result_written`, `result_o` and `flags_o`. Without `in_valid`, `result_o` and `flags_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| cmp_mode | input | 1 | 1 = compare (flags only) |
| width_sel | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 |
| dst_i | input | 64 | Destination (minuend) |
| src_i | input | 64 | Source (subtrahend) |
| flags_i | input | 32 | Incoming status word |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result_o | output | 64 | Truncated difference |
| flags_o | output | 32 | Updated status word |
| result_written | output | 1 | 1 when result_o was updated by the last operation |

## Verification
On every cycle the assertions check the following:
- the one-clock valid timing;
- that the result holds in compare mode;
- that the non-arithmetic status bits are copied;
- that the zero and parity flags agree with the written result, whatever the width.

Only the scenarios can show that borrow, half borrow, overflow and sign are numerically correct at each width, and that operand bits above the width are ignored. The bench covers the extreme operands, such as 0 minus 1 and the most negative value minus 1, back-to-back streams and a long pseudo-random stream.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int NUM_WIDTHS = 4;
  localparam int SEL_W      = $clog2(NUM_WIDTHS);
  localparam int DATA_W     = 8 << (NUM_WIDTHS - 1);
  localparam int FLAG_W     = 32;

  localparam int BRW_POS = 0;
  localparam int PAR_POS = 2;
  localparam int HBR_POS = 4;
  localparam int ZER_POS = 6;
  localparam int SGN_POS = 7;
  localparam int OVF_POS = 11;

  typedef struct packed {
    logic brw;
    logic par;
    logic hbr;
    logic zer;
    logic sgn;
    logic ovf;
  } status_t;

  function automatic logic [FLAG_W-1:0] arith_bits();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[BRW_POS] = 1'b1;
    m[PAR_POS] = 1'b1;
    m[HBR_POS] = 1'b1;
    m[ZER_POS] = 1'b1;
    m[SGN_POS] = 1'b1;
    m[OVF_POS] = 1'b1;
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] merge_status(input logic [FLAG_W-1:0] fin,
                                                     input status_t st);
    logic [FLAG_W-1:0] w;
    w = fin;
    w[BRW_POS] = st.brw;
    w[PAR_POS] = st.par;
    w[HBR_POS] = st.hbr;
    w[ZER_POS] = st.zer;
    w[SGN_POS] = st.sgn;
    w[OVF_POS] = st.ovf;
    return w;
  endfunction

  function automatic logic even_ones8(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic pick_bit(input logic [DATA_W-1:0] v,
                                    input logic [DATA_W-1:0] onehot);
    return |(v & onehot);
  endfunction
endpackage

// File: rtl/sfu_lane_select.sv
module sfu_lane_select #(
  parameter int NUM_WIDTHS = sfu_pkg::NUM_WIDTHS,
  parameter int SEL_W      = sfu_pkg::SEL_W,
  parameter int DATA_W     = sfu_pkg::DATA_W
) (
  input  logic [SEL_W-1:0]  width_sel,
  output logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] lane_msb
);
  logic [DATA_W-1:0] mask_tab [NUM_WIDTHS];
  logic [DATA_W-1:0] msb_tab  [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_lane
    localparam int LW = 8 << g;
    if (LW >= DATA_W) begin : g_full
      assign mask_tab[g] = '1;
    end else begin : g_part
      assign mask_tab[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
    end
    assign msb_tab[g] = {{(DATA_W-1){1'b0}}, 1'b1} << (LW - 1);
  end

  assign lane_mask = mask_tab[width_sel];
  assign lane_msb  = msb_tab[width_sel];
endmodule

// File: rtl/sfu_flag_core.sv
module sfu_flag_core
  import sfu_pkg::*;
#(
  parameter int DATA_W = sfu_pkg::DATA_W,
  parameter int FLAG_W = sfu_pkg::FLAG_W
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] lane_msb,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] diff,
  output logic [FLAG_W-1:0] flags_out,
  output logic              add_carry
);
  logic [DATA_W-1:0] dm, sm, sm_inv;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] ovf_vec, half_vec;
  status_t           st;

  assign dm     = dst & lane_mask;
  assign sm     = src & lane_mask;
  assign sm_inv = ~src & lane_mask;

  // Subtract as add of the inverted source plus one; carry out lands one above the lane MSB.
  assign sum       = {1'b0, dm} + {1'b0, sm_inv} + {{DATA_W{1'b0}}, 1'b1};
  assign add_carry = pick_bit(sum[DATA_W:1], lane_msb);
  assign diff      = sum[DATA_W-1:0] & lane_mask;

  assign ovf_vec  = (dm ^ sm) & (dm ^ diff);
  assign half_vec = dm ^ sm ^ diff;

  always_comb begin
    st.brw = ~add_carry;
    st.par = even_ones8(diff[7:0]);
    st.hbr = half_vec[4];
    st.zer = (diff == '0);
    st.sgn = pick_bit(diff, lane_msb);
    st.ovf = pick_bit(ovf_vec, lane_msb);
  end

  assign flags_out = merge_status(flags_in, st);
endmodule

// File: rtl/sub_flag_unit.sv
module sub_flag_unit
  import sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              cmp_mode,
  input  logic [1:0]        width_sel,
  input  logic [63:0]       dst_i,
  input  logic [63:0]       src_i,
  input  logic [31:0]       flags_i,
  output logic              out_valid,
  output logic [63:0]       result_o,
  output logic [31:0]       flags_o,
  output logic              result_written
);
  logic [DATA_W-1:0] lane_mask, lane_msb, diff_w;
  logic [FLAG_W-1:0] next_flags;
  logic              add_carry;

  sfu_lane_select u_lane (
    .width_sel (width_sel),
    .lane_mask (lane_mask),
    .lane_msb  (lane_msb)
  );

  sfu_flag_core u_core (
    .dst       (dst_i),
    .src       (src_i),
    .lane_mask (lane_mask),
    .lane_msb  (lane_msb),
    .flags_in  (flags_i),
    .diff      (diff_w),
    .flags_out (next_flags),
    .add_carry (add_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result_written <= 1'b0;
      result_o       <= '0;
      flags_o        <= '0;
    end else begin
      out_valid      <= in_valid;
      result_written <= in_valid & ~cmp_mode;
      if (in_valid) begin
        flags_o <= next_flags;
        if (!cmp_mode) result_o <= diff_w;
      end
    end
  end
endmodule

module sfu_checker
  import sfu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        cmp_mode,
  input logic [31:0] flags_i,
  input logic        out_valid,
  input logic [63:0] result_o,
  input logic [31:0] flags_o,
  input logic        result_written
);
  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode) |=> ($stable(result_o) && !result_written));
  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((flags_o & ~arith_bits()) == ($past(flags_i) & ~arith_bits())));
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result_written) |-> (flags_o[ZER_POS] == (result_o == 64'd0)));
  // R3
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result_written) |-> (flags_o[PAR_POS] == ~(^result_o[7:0])));
endmodule

bind sub_flag_unit sfu_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .cmp_mode       (cmp_mode),
  .flags_i        (flags_i),
  .out_valid      (out_valid),
  .result_o       (result_o),
  .flags_o        (flags_o),
  .result_written (result_written)
);

// File: tb/tb_sub_flag_unit.sv
module tb_sub_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        cmp_mode = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [31:0] flags_i = '0;
  logic        out_valid;
  logic [63:0] result_o;
  logic [31:0] flags_o;
  logic        result_written;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] res;
    logic [31:0] flg;
    logic        wr;
    string       tag;
  } item_t;
  item_t exp_q[$];
  logic [63:0] model_last = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  sub_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmp_mode(cmp_mode),
    .width_sel(width_sel), .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
    .out_valid(out_valid), .result_o(result_o), .flags_o(flags_o),
    .result_written(result_written)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input int w, input logic [63:0] d_in, input logic [63:0] s_in,
                                input logic [31:0] fin, output logic [63:0] r,
                                output logic [31:0] fo);
    int          bits;
    logic [63:0] mask, d, s;
    logic [64:0] wide;
    int          ones;
    logic        sd, ss, sr;
    bits = 8 << w;
    mask = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
    d = d_in & mask;
    s = s_in & mask;
    wide = {1'b0, d} - {1'b0, s};
    r = wide[63:0] & mask;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    sd = d[bits-1]; ss = s[bits-1]; sr = r[bits-1];
    fo = fin;
    fo[0]  = (d < s);
    fo[2]  = (ones % 2) == 0;
    fo[4]  = (d[3:0] < s[3:0]);
    fo[6]  = (r == 64'd0);
    fo[7]  = sr;
    fo[11] = (sd != ss) && (sr != sd);
  endfunction

  task automatic send(input int w, input logic [63:0] d, input logic [63:0] s,
                      input logic [31:0] f, input bit cmp, input string tag);
    item_t it;
    logic [63:0] r;
    logic [31:0] fo;
    model(w, d, s, f, r, fo);
    @(negedge clk);
    in_valid = 1'b1; cmp_mode = cmp; width_sel = 2'(w);
    dst_i = d; src_i = s; flags_i = f;
    if (!cmp) model_last = r;
    it.res = model_last; it.flg = fo; it.wr = !cmp; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      dst_i = seed; src_i = ~seed; cmp_mode = 1'b0;
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected out_valid", 64'd1, 64'd0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(result_o == e.res, e.tag, "result", result_o, e.res);
        check(flags_o == e.flg, e.tag, "flags", {32'd0, flags_o}, {32'd0, e.flg});
        check(result_written == e.wr, e.tag, "written", {63'd0, result_written}, {63'd0, e.wr});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check(result_o == 64'd0, "R9", "reset result", result_o, 64'd0);
    check(result_written == 1'b0, "R9", "reset written", {63'd0, result_written}, 64'd0);
    rst_n = 1'b1;
    idle(2);

    send(0, 64'h10, 64'h01, 32'h0, 0, "R4");
    send(0, 64'h00, 64'h01, 32'h0, 0, "R2");
    send(0, 64'h80, 64'h01, 32'h0, 0, "R5");
    send(0, 64'h55, 64'h55, 32'hFFFF_FFFF, 0, "R6");
    send(0, 64'hFFFF_FFFF_FFFF_AB12, 64'h1234_5678_9ABC_FF01, 32'h0, 0, "R1");
    send(0, 64'h03, 64'h00, 32'h0, 0, "R3");
    idle(1);
    send(1, 64'h0000, 64'h8000, 32'hA5A5_0A5A, 0, "R5");
    send(1, 64'h7FFF_0100, 64'h0001, 32'h0, 0, "R3");
    send(2, 64'h0, 64'h1, 32'h1234_5678, 0, "R2");
    send(2, 64'hDEAD_0000_8000_0000, 64'h1, 32'h0, 0, "R5");
    send(3, 64'h0, 64'h1, 32'h0, 0, "R6");
    send(3, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 0, "R5");
    send(3, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 32'hFFFF_F728, 0, "R6");
    send(3, 64'h3, 64'h5, 32'hFFFF_FFFF, 1, "R8");
    send(1, 64'h0, 64'h0, 32'h0000_F000, 1, "R8");
    idle(3);
    send(2, 64'hFFFF_FFFF, 64'h1, 32'hFEDC_BA98, 0, "R7");
    send(0, 64'h20, 64'h30, 32'h0, 1, "R8");
    idle(2);

    for (int k = 0; k < 60; k++) begin
      logic [63:0] a, b, f;
      a = next_rand(); b = next_rand(); f = next_rand();
      send(int'(a[1:0] ^ b[3:2]), a, (k % 5 == 0) ? a ^ 64'h10 : b, f[31:0],
           (k % 7 == 3), (k % 2 == 0) ? "R1" : "R7");
      if (k % 9 == 4) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R9", "missing outputs", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule